// File: doc/BRIEF.md
# Per-Core Line Slot Predictor

In a hybrid memory, one line of a congruence group may sit in any of four physical slots: the fast stacked slot (code 0) or one of three off-chip slots (codes 1 to 3). This block guesses the slot from the instruction address of the access. That lets the memory controller start a speculative fetch from the guessed slot at the same time as the stacked access. The fetch does not wait for the real location record to come back.

Each core has its own small table of 2-bit slot codes. The lookup is combinational: the requesting core and instruction address go in, and a slot code comes out in the same cycle. When the real slot is known, the caller presents it on the update port. The block then reports at once whether the stored guess was wrong. In the same clock edge it overwrites the entry with the real slot, so the last observed location becomes the next guess. Two saturating counters keep the number of correct and incorrect guesses.

Top module: `line_slot_predictor`

## Requirements
- R1: After reset, every entry of every core predicts slot code 0 (stacked), and both counters read 0.
- R2: The entry is chosen by instruction address bits [OFFSET_W +: IDX_W]. Addresses that differ only in the low OFFSET_W bits, or only above the index field, use the same entry.
- R3: On a clock edge with `upd_valid` high, the entry chosen by `upd_core` and `upd_pc` takes `upd_slot`. From the next cycle on, a lookup of that entry returns it.
- R4: An update changes only the table of the core named by `upd_core`. The same index in any other core is left unchanged.
- R5: `upd_wrong` is high in the same cycle as an update exactly when the stored entry differs from `upd_slot`. It is low whenever `upd_valid` is low.
- R6: Each update adds 1 to `good_count` if `upd_wrong` is low, or to `bad_count` if it is high. The new value is visible from the cycle after the update.
- R7: Each counter stops at its all-ones value and stays there on further increments.
- R8: When an update and a lookup target the same core and entry in the same cycle, the lookup returns `upd_slot`.
- R9: `pred_slot` follows changes of `look_core` and `look_pc` within the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| look_core | input | CORE_W | Core issuing the lookup |
| look_pc | input | ADDR_W | Instruction address of the lookup |
| pred_slot | output | SLOT_W | Predicted slot code (0 stacked, 1 to 3 off-chip) |
| upd_valid | input | 1 | Resolved location present this cycle |
| upd_core | input | CORE_W | Core of the resolved access |
| upd_pc | input | ADDR_W | Instruction address of the resolved access |
| upd_slot | input | SLOT_W | Real slot code found by the table lookup |
| upd_wrong | output | 1 | Stored guess differed from the real slot |
| good_count | output | CNT_W | Saturating count of correct guesses |
| bad_count | output | CNT_W | Saturating count of wrong guesses |

## Verification
The hardest case to reach from the ports is counter saturation. It needs more wrong or more correct updates than the counter can hold, and a normal sweep rarely produces that many. The bench works on a reduced configuration with a 5-bit counter. It first sweeps every entry of every core several times against a reference array, and then hammers one entry with alternating slots followed by repeated identical slots. This drives each counter past its ceiling. The bench also sends each update together with a lookup of the same entry, so the same-cycle priority case is checked on every update.

// File: rtl/slp_pkg.sv
package slp_pkg;
   typedef enum logic [1:0] {
      SLOT_STACKED = 2'd0,
      SLOT_FAR1    = 2'd1,
      SLOT_FAR2    = 2'd2,
      SLOT_FAR3    = 2'd3
   } slot_code_e;

   function automatic int unsigned safe_clog2(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/slp_sat_counter.sv
module slp_sat_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] value
);
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   if (CNT_W < 1) begin : g_bad_w
      $error("slp_sat_counter: CNT_W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         value <= '0;
      else if (inc && value != TOP)
         value <= value + 1'b1;
   end

   // R6
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && value != TOP) |=> value == $past(value) + 1'b1);
   // R7
   cnt_hold_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (value == TOP) |=> value == TOP);
   // R6
   cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(value));
endmodule

// File: rtl/slp_core_table.sv
module slp_core_table #(
   parameter int IDX_W  = 8,
   parameter int SLOT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [SLOT_W-1:0] rd_slot,
   input  logic [IDX_W-1:0]  chk_idx,
   output logic [SLOT_W-1:0] chk_slot,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [SLOT_W-1:0] wr_slot
);
   localparam int DEPTH = 1 << IDX_W;

   if (IDX_W < 1 || IDX_W > 10) begin : g_bad_idx
      $error("slp_core_table: IDX_W out of range");
   end

   logic [SLOT_W-1:0] ent [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) ent[e] <= '0;
      end else if (wr_en) begin
         ent[wr_idx] <= wr_slot;
      end
   end

   assign rd_slot  = ent[rd_idx];
   assign chk_slot = ent[chk_idx];

   // R3
   entry_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ent[$past(wr_idx)] == $past(wr_slot));
endmodule

// File: rtl/line_slot_predictor.sv
module line_slot_predictor
   import slp_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int ADDR_W    = 48,
   parameter int OFFSET_W  = 2,
   parameter int IDX_W     = 8,
   parameter int SLOT_W    = 2,
   parameter int CNT_W     = 16,
   parameter int CORE_W    = safe_clog2(NUM_CORES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CORE_W-1:0] look_core,
   input  logic [ADDR_W-1:0] look_pc,
   output logic [SLOT_W-1:0] pred_slot,
   input  logic              upd_valid,
   input  logic [CORE_W-1:0] upd_core,
   input  logic [ADDR_W-1:0] upd_pc,
   input  logic [SLOT_W-1:0] upd_slot,
   output logic              upd_wrong,
   output logic [CNT_W-1:0]  good_count,
   output logic [CNT_W-1:0]  bad_count
);
   if (OFFSET_W + IDX_W > ADDR_W) begin : g_bad_addr
      $error("line_slot_predictor: index field exceeds address width");
   end
   if (NUM_CORES < 1) begin : g_bad_cores
      $error("line_slot_predictor: NUM_CORES must be at least 1");
   end
   if (SLOT_W != 2) begin : g_bad_slot
      $error("line_slot_predictor: four slots need SLOT_W of 2");
   end

   logic [IDX_W-1:0]  look_idx, upd_idx;
   logic [CORE_W-1:0] look_sel, upd_sel;
   logic [SLOT_W-1:0] rd_slot  [NUM_CORES];
   logic [SLOT_W-1:0] chk_slot [NUM_CORES];
   logic [SLOT_W-1:0] table_guess, stored_guess;
   logic              same_entry;

   assign look_idx = look_pc[OFFSET_W +: IDX_W];
   assign upd_idx  = upd_pc[OFFSET_W +: IDX_W];

   if (NUM_CORES == 1) begin : g_single
      assign look_sel = '0;
      assign upd_sel  = '0;
   end else begin : g_multi
      assign look_sel = look_core;
      assign upd_sel  = upd_core;
   end

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      logic wr_here;
      assign wr_here = upd_valid && (upd_sel == CORE_W'(c));
      slp_core_table #(.IDX_W(IDX_W), .SLOT_W(SLOT_W)) tbl_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .rd_idx   (look_idx),
         .rd_slot  (rd_slot[c]),
         .chk_idx  (upd_idx),
         .chk_slot (chk_slot[c]),
         .wr_en    (wr_here),
         .wr_idx   (upd_idx),
         .wr_slot  (upd_slot)
      );
   end

   always_comb begin
      table_guess  = '0;
      stored_guess = '0;
      for (int c = 0; c < NUM_CORES; c++) begin
         if (look_sel == CORE_W'(c)) table_guess  = rd_slot[c];
         if (upd_sel  == CORE_W'(c)) stored_guess = chk_slot[c];
      end
   end

   assign same_entry = upd_valid && (upd_sel == look_sel) && (upd_idx == look_idx);
   assign pred_slot  = same_entry ? upd_slot : table_guess;
   assign upd_wrong  = upd_valid && (stored_guess != upd_slot);

   slp_sat_counter #(.CNT_W(CNT_W)) good_i (
      .clk(clk), .rst_n(rst_n), .inc(upd_valid && !upd_wrong), .value(good_count));
   slp_sat_counter #(.CNT_W(CNT_W)) bad_i (
      .clk(clk), .rst_n(rst_n), .inc(upd_wrong), .value(bad_count));

   // R5
   wrong_needs_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_valid |-> !upd_wrong);
   // R6
   one_count_per_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_valid |=> ($stable(good_count) && $stable(bad_count)));
endmodule

// File: tb/line_slot_predictor_tb.sv
`timescale 1ns/1ps
module line_slot_predictor_tb_top;
   localparam int NC = 2, AW = 12, OW = 2, IW = 3, SW = 2, CW = 5, KW = 1;
   localparam int DEP = 1 << IW;
   localparam int TOP = (1 << CW) - 1;

   logic clk = 0, rst_n = 0;
   logic [KW-1:0] look_core = '0, upd_core = '0;
   logic [AW-1:0] look_pc = '0, upd_pc = '0;
   logic [SW-1:0] upd_slot = '0, pred_slot;
   logic upd_valid = 0, upd_wrong;
   logic [CW-1:0] good_count, bad_count;

   int vecs = 0, errs = 0;
   int exp_good = 0, exp_bad = 0;
   logic [1:0] model [NC][DEP];

   always #2.5 clk = ~clk;

   line_slot_predictor #(.NUM_CORES(NC), .ADDR_W(AW), .OFFSET_W(OW), .IDX_W(IW),
      .SLOT_W(SW), .CNT_W(CW), .CORE_W(KW)) dut_i (
      .clk(clk), .rst_n(rst_n), .look_core(look_core), .look_pc(look_pc),
      .pred_slot(pred_slot), .upd_valid(upd_valid), .upd_core(upd_core),
      .upd_pc(upd_pc), .upd_slot(upd_slot), .upd_wrong(upd_wrong),
      .good_count(good_count), .bad_count(bad_count));

   function automatic logic [AW-1:0] mk_pc(int hi, int idx, int off);
      return AW'((hi << (OW + IW)) | (idx << OW) | off);
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      vecs++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_update(int c, int hi, int idx, int off, int s);
      bit expw;
      @(negedge clk);
      upd_valid = 1; upd_core = KW'(c); upd_pc = mk_pc(hi, idx, off); upd_slot = SW'(s);
      look_core = KW'(c); look_pc = mk_pc(hi + 1, idx, (off + 1) % 4);
      #1;
      expw = (model[c][idx] != 2'(s));
      check(upd_wrong == expw, "R5 wrong flag", upd_wrong, expw);
      check(pred_slot == SW'(s), "R8 same-cycle priority", pred_slot, s);
      @(posedge clk);
      model[c][idx] = 2'(s);
      if (expw) begin if (exp_bad < TOP) exp_bad++; end
      else begin if (exp_good < TOP) exp_good++; end
      #1 upd_valid = 0;
      #0.5;
      check(good_count == CW'(exp_good), "R6/R7 good_count", good_count, exp_good);
      check(bad_count == CW'(exp_bad), "R6/R7 bad_count", bad_count, exp_bad);
      check(pred_slot == SW'(s), "R3 stored slot", pred_slot, s);
   endtask

   initial begin : watchdog
      #400000;
      errs++; vecs++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      for (int c = 0; c < NC; c++) for (int i = 0; i < DEP; i++) model[c][i] = 2'd0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1: reset state of every entry and both counters
      @(negedge clk);
      check(good_count == 0 && bad_count == 0, "R1 counters", good_count + bad_count, 0);
      for (int c = 0; c < NC; c++) for (int i = 0; i < DEP; i++) begin
         look_core = KW'(c); look_pc = mk_pc(c + 5, i, 3); #0.2;
         check(pred_slot == 0, "R1 entry", pred_slot, 0);
      end
      // Sweep: three rounds over all entries; round 2 repeats round 1 for hits
      for (int r = 0; r < 3; r++)
         for (int c = 0; c < NC; c++)
            for (int i = 0; i < DEP; i++)
               do_update(c, r + i, i, (i + r) % 4, (c + i + (r == 2 ? 1 : r)) % 4);
      // R2: aliasing addresses share the entry; R9: lookup is combinational
      @(negedge clk);
      for (int c = 0; c < NC; c++) for (int i = 0; i < DEP; i++) begin
         look_core = KW'(c); look_pc = mk_pc((i * 7 + 3) % 64, i, (i * 3) % 4); #0.2;
         check(pred_slot == SW'(model[c][i]), "R2/R9 alias lookup", pred_slot, model[c][i]);
      end
      // R4: core isolation
      do_update(0, 1, 0, 0, (model[0][0] + 1) % 4);
      @(negedge clk);
      look_core = 1; look_pc = mk_pc(1, 0, 0); #0.2;
      check(pred_slot == SW'(model[1][0]), "R4 other core untouched", pred_slot, model[1][0]);
      // R7: saturate bad then good counter on one entry
      for (int k = 0; k < 40; k++) do_update(1, 2, 5, 1, (model[1][5] + 1) % 4);
      check(bad_count == CW'(TOP), "R7 bad saturated", bad_count, TOP);
      for (int k = 0; k < 40; k++) do_update(1, 2, 5, 1, model[1][5]);
      check(good_count == CW'(TOP), "R7 good saturated", good_count, TOP);
      // R5: flag low without update
      @(negedge clk); #0.2;
      check(upd_wrong == 0, "R5 idle flag", upd_wrong, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule